// File: doc/BRIEF.md
# Ownership-Gated In-Order Store Buffer

This block holds a core's retired stores between the store pipeline and the private L1 data cache. Each store carries a byte address, a data word and a byte mask. Stores enter at the tail and leave at the head, strictly oldest first. A store leaves only when the local cache holds its line with write permission, meaning the line is in the Modified or Exclusive state. The store becomes globally visible in the cycle it is written into the cache.

When the line at the head is not owned, the buffer asks the coherence fabric for ownership with a read-for-ownership request. It then waits for the acknowledge. If the fabric reports that the line was lost while the request was in flight, the buffer asks again. No buffered store is ever dropped.

Loads issued by the core look into the buffer. A load whose bytes are all supplied by the youngest overlapping store takes its data from the buffer. A load that only partly overlaps that store is stalled. A full-fence pulse blocks all later loads and stores until every buffered store has reached the cache.

Top module: `coh_store_buffer`

## Requirements
- R1: After reset the buffer is empty. `stReady` is 1, and `cmtValid`, `rfoReq`, `memStall`, `ldFwdHit` and `ldStall` are all 0.
- R2: The buffer holds up to DEPTH (default 8) stores. A store is accepted in a cycle where `stValid` and `stReady` are both high. `stReady` is low while DEPTH stores are held.
- R3: Stores reach the cache port in the order they were accepted. Each one carries its own address, data and mask unchanged.
- R4: `cmtValid` is high exactly when the buffer is non-empty and `headOwned` is high. At most one store commits per cycle. A store accepted at an edge can commit in the very next cycle.
- R5: `headLine` always shows bits [AW-1:6] of the oldest store's address (64-byte lines). `rfoReq` pulses for one cycle when the head line is not owned and no request is outstanding. A request stays outstanding until `rfoAck` arrives, and no second request is raised while one is outstanding.
- R6: `ownLost` with `ownLostLine` equal to the head line, while a request is outstanding, cancels that request. A new `rfoReq` is raised in the next cycle if the line is still not owned. `ownLost` for any other line has no effect.
- R7: A load matches a buffered store when address bits [AW-1:2] are equal and their byte masks overlap. If the youngest matching store's mask covers every requested byte, `ldFwdHit` is 1 and `ldFwdData` is that store's data word.
- R8: If the youngest matching store covers only part of the requested bytes, `ldStall` is 1 and `ldFwdHit` is 0.
- R9: A `fenceReq` pulse raises `memStall` from the next cycle until the buffer is empty. While `memStall` is high, `stReady` is 0 and any valid load sees `ldStall` = 1. A fence issued while the buffer is empty stalls for exactly one cycle.
- R10: A load that overlaps no buffered store gives `ldFwdHit` = 0 and `ldStall` = 0. This holds even when a store to the same word with disjoint bytes is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store offered by the pipeline |
| stReady | output | 1 | Buffer accepts the store this cycle |
| stAddr | input | AW | Store byte address (word aligned) |
| stData | input | DW | Store data word |
| stMask | input | DW/8 | Store byte enables |
| ldValid | input | 1 | Load lookup this cycle |
| ldAddr | input | AW | Load byte address |
| ldMask | input | DW/8 | Requested bytes |
| ldFwdHit | output | 1 | Load fully served from the buffer |
| ldFwdData | output | DW | Forwarded data word |
| ldStall | output | 1 | Load must wait (partial overlap or fence) |
| fenceReq | input | 1 | Full-fence pulse |
| memStall | output | 1 | Fence drain in progress |
| headLine | output | AW-6 | Line of the oldest store, for the ownership lookup |
| headOwned | input | 1 | Cache holds headLine in Modified or Exclusive state |
| rfoReq | output | 1 | Read-for-ownership request for headLine |
| rfoAck | input | 1 | Ownership granted, other copies invalidated |
| ownLost | input | 1 | Ownership of a line was lost |
| ownLostLine | input | AW-6 | Line named by ownLost |
| cmtValid | output | 1 | Oldest store written into the cache this cycle |
| cmtAddr | output | AW | Committed address |
| cmtData | output | DW | Committed data |
| cmtMask | output | DW/8 | Committed byte enables |

## Verification
A corrupted pointer or valid bit surfaces at the cache port within one cycle of the head reaching an owned line. It shows up as a reordered, duplicated or missing commit, and the per-cycle model comparison catches it. A wrong outstanding-request flag shows on the next cycle as either a repeated `rfoReq` or a missing one. This is most visible after an ownership-lost event. A stuck fence flag shows as `stReady` staying low once the buffer has drained. A fault in the youngest-first search shows at the load port in the same cycle as the lookup, because two stores to one word with different masks are buffered together.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Strobes issued by the control block to the entry datapath.
  typedef struct packed {
    logic push;
    logic pop;
  } sbStrobe_t;

  // Outcome of the forwarding search for one load lookup.
  typedef enum logic [1:0] {
    FWD_NONE    = 2'd0,
    FWD_HIT     = 2'd1,
    FWD_PARTIAL = 2'd2
  } fwdRes_t;

endpackage

// File: rtl/sb_data.sv
module sb_data
  import sb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbStrobe_t         strb,
  input  logic [AW-1:0]     stAddr,
  input  logic [DW-1:0]     stData,
  input  logic [DW/8-1:0]   stMask,
  input  logic [AW-1:0]     ldAddr,
  input  logic [DW/8-1:0]   ldMask,
  output logic              headValid,
  output logic [AW-1:0]     headAddr,
  output logic [DW-1:0]     headData,
  output logic [DW/8-1:0]   headMask,
  output fwdRes_t           fwdRes,
  output logic [DW-1:0]     fwdData
);
  localparam int MW = DW / 8;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WO = (MW > 1) ? $clog2(MW) : 0;

  logic [AW-1:0]  addrQ [DEPTH];
  logic [DW-1:0]  dataQ [DEPTH];
  logic [MW-1:0]  maskQ [DEPTH];
  logic [DEPTH-1:0] validQ;
  logic [PW-1:0]  wrPtr, rdPtr;

  // Ring pointers and per-entry valid bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      validQ <= '0;
    end else begin
      if (strb.push) begin
        wrPtr <= PW'(wrPtr + 1'b1);
      end
      if (strb.pop) begin
        rdPtr <= PW'(rdPtr + 1'b1);
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.push && (wrPtr == PW'(i))) begin
          validQ[i] <= 1'b1;
        end else if (strb.pop && (rdPtr == PW'(i))) begin
          validQ[i] <= 1'b0;
        end
      end
    end
  end

  // Entry payload storage, written in place without reset
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gEntry
      always_ff @(posedge clk) begin
        if (strb.push && (wrPtr == PW'(g))) begin
          addrQ[g] <= stAddr;
          dataQ[g] <= stData;
          maskQ[g] <= stMask;
        end
      end
    end
  endgenerate

  assign headValid = validQ[rdPtr];
  assign headAddr  = addrQ[rdPtr];
  assign headData  = dataQ[rdPtr];
  assign headMask  = maskQ[rdPtr];

  // Youngest-first search for an overlapping store to the same word
  logic [PW-1:0] idx;
  logic          found;
  logic [MW-1:0] ovl;
  always_comb begin
    fwdRes  = FWD_NONE;
    fwdData = '0;
    found   = 1'b0;
    idx     = '0;
    ovl     = '0;
    for (int age = 0; age < DEPTH; age++) begin
      idx = PW'(wrPtr - PW'(age + 1));
      ovl = maskQ[idx] & ldMask;
      if (!found && validQ[idx] && (|ovl) &&
          (addrQ[idx][AW-1:WO] == ldAddr[AW-1:WO])) begin
        found   = 1'b1;
        fwdData = dataQ[idx];
        fwdRes  = (ovl == ldMask) ? FWD_HIT : FWD_PARTIAL;
      end
    end
  end

  // R2: when the pointers meet on a valid entry, the ring is completely full
  a_r2_full_ring: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr == rdPtr && validQ[rdPtr]) |-> (&validQ));

  // R3: a pop leaves the old head slot invalid unless it was refilled in the same cycle
  a_r3_pop_frees: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push) |=> !validQ[$past(rdPtr)]);

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int LB    = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  input  logic          ldValid,
  input  logic          fenceReq,
  input  logic          headValid,
  input  logic [AW-LB-1:0] headLine,
  input  logic          headOwned,
  input  logic          rfoAck,
  input  logic          ownLost,
  input  logic [AW-LB-1:0] ownLostLine,
  input  fwdRes_t       fwdRes,
  output sbStrobe_t     strb,
  output logic          stReady,
  output logic          memStall,
  output logic          cmtValid,
  output logic          rfoReq,
  output logic          ldFwdHit,
  output logic          ldStall
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [CW-1:0] count, countNext;
  logic          rfoBusy;
  logic          fencePending;
  logic          full;
  logic          lostHit;

  assign full     = (count == CW'(DEPTH));
  assign stReady  = !full && !fencePending;
  assign memStall = fencePending;

  assign cmtValid  = headValid && headOwned;
  assign strb.push = stValid && stReady;
  assign strb.pop  = cmtValid;

  assign countNext = count + CW'(strb.push) - CW'(strb.pop);

  assign rfoReq  = headValid && !headOwned && !rfoBusy;
  assign lostHit = ownLost && (ownLostLine == headLine);

  assign ldFwdHit = ldValid && !fencePending && (fwdRes == FWD_HIT);
  assign ldStall  = ldValid && (fencePending || (fwdRes == FWD_PARTIAL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count        <= '0;
      rfoBusy      <= 1'b0;
      fencePending <= 1'b0;
    end else begin
      count <= countNext;
      if (rfoReq) begin
        rfoBusy <= 1'b1;
      end else if (rfoBusy && (rfoAck || lostHit)) begin
        rfoBusy <= 1'b0;
      end
      fencePending <= fenceReq || (fencePending && (countNext != '0));
    end
  end

  // R2: occupancy never exceeds the configured depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R3: the control count and the datapath head flag agree
  a_r3_head_consistent: assert property (@(posedge clk) disable iff (!rstN)
    headValid == (count != '0));

  // R5: a request is never repeated in back-to-back cycles
  a_r5_single_rfo: assert property (@(posedge clk) disable iff (!rstN)
    rfoReq |=> !rfoReq);

  // R9: a fence pulse blocks new stores from the following cycle
  a_r9_fence_blocks: assert property (@(posedge clk) disable iff (!rstN)
    fenceReq |=> (memStall && !stReady));

  // R9: an empty buffer releases the fence one cycle later
  a_r9_fence_release: assert property (@(posedge clk) disable iff (!rstN)
    (memStall && count == '0 && !fenceReq) |=> !memStall);

  // R8: a load is never both forwarded and stalled
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    ldStall |-> !ldFwdHit);

endmodule

// File: rtl/coh_store_buffer.sv
module coh_store_buffer
  import sb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int LB    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  output logic              stReady,
  input  logic [AW-1:0]     stAddr,
  input  logic [DW-1:0]     stData,
  input  logic [DW/8-1:0]   stMask,
  input  logic              ldValid,
  input  logic [AW-1:0]     ldAddr,
  input  logic [DW/8-1:0]   ldMask,
  output logic              ldFwdHit,
  output logic [DW-1:0]     ldFwdData,
  output logic              ldStall,
  input  logic              fenceReq,
  output logic              memStall,
  output logic [AW-LB-1:0]  headLine,
  input  logic              headOwned,
  output logic              rfoReq,
  input  logic              rfoAck,
  input  logic              ownLost,
  input  logic [AW-LB-1:0]  ownLostLine,
  output logic              cmtValid,
  output logic [AW-1:0]     cmtAddr,
  output logic [DW-1:0]     cmtData,
  output logic [DW/8-1:0]   cmtMask
);
  sbStrobe_t     strb;
  fwdRes_t       fwdRes;
  logic          headValid;
  logic [AW-1:0] headAddr;

  sb_data #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .stAddr(stAddr), .stData(stData), .stMask(stMask),
    .ldAddr(ldAddr), .ldMask(ldMask),
    .headValid(headValid), .headAddr(headAddr),
    .headData(cmtData), .headMask(cmtMask),
    .fwdRes(fwdRes), .fwdData(ldFwdData)
  );

  assign headLine = headAddr[AW-1:LB];
  assign cmtAddr  = headAddr;

  sb_ctrl #(.AW(AW), .DEPTH(DEPTH), .LB(LB)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .stValid(stValid), .ldValid(ldValid), .fenceReq(fenceReq),
    .headValid(headValid), .headLine(headLine), .headOwned(headOwned),
    .rfoAck(rfoAck), .ownLost(ownLost), .ownLostLine(ownLostLine),
    .fwdRes(fwdRes), .strb(strb),
    .stReady(stReady), .memStall(memStall), .cmtValid(cmtValid),
    .rfoReq(rfoReq), .ldFwdHit(ldFwdHit), .ldStall(ldStall)
  );

  // R4: nothing is written to the cache for a line that is not owned
  a_r4_commit_owned: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid |-> headOwned);

  // R5: a request is only raised for a line that is not yet owned
  a_r5_rfo_unowned: assert property (@(posedge clk) disable iff (!rstN)
    rfoReq |-> !headOwned);

endmodule

// File: tb/coh_store_buffer_tb_top.sv
`timescale 1ns/100ps
module coh_store_buffer_tb_top;
  localparam int AW = 32, DW = 32, MW = 4, DEPTH = 8, LB = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 0, ldValid = 0, fenceReq = 0, headOwned = 0, rfoAck = 0, ownLost = 0;
  logic [AW-1:0] stAddr = '0, ldAddr = '0;
  logic [DW-1:0] stData = '0;
  logic [MW-1:0] stMask = '0, ldMask = '0;
  logic [AW-LB-1:0] ownLostLine = '0;
  logic stReady, ldFwdHit, ldStall, memStall, rfoReq, cmtValid;
  logic [DW-1:0] ldFwdData, cmtData;
  logic [AW-1:0] cmtAddr;
  logic [MW-1:0] cmtMask;
  logic [AW-LB-1:0] headLine;

  always #2.5 clk = ~clk;

  coh_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .LB(LB)) dut_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .stMask(stMask),
    .ldValid(ldValid), .ldAddr(ldAddr), .ldMask(ldMask),
    .ldFwdHit(ldFwdHit), .ldFwdData(ldFwdData), .ldStall(ldStall),
    .fenceReq(fenceReq), .memStall(memStall), .headLine(headLine),
    .headOwned(headOwned), .rfoReq(rfoReq), .rfoAck(rfoAck),
    .ownLost(ownLost), .ownLostLine(ownLostLine),
    .cmtValid(cmtValid), .cmtAddr(cmtAddr), .cmtData(cmtData), .cmtMask(cmtMask)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic [MW-1:0] m; } ent_t;
  ent_t q[$];
  bit   owned [logic [AW-LB-1:0]];
  bit   rb = 0, fp = 0, ackEn = 0;
  int   ackCnt = 0, total = 0, bad = 0;
  logic [AW-LB-1:0] mLine;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive the cache and fabric responses from the reference state
  task automatic settleEnv();
    mLine     = (q.size() != 0) ? q[0].a[AW-1:LB] : '0;
    headOwned = (q.size() != 0) && owned.exists(mLine);
    rfoAck    = rb && ackEn && (ackCnt >= 2);
    #1;
  endtask

  task automatic step();
    bit eReady, eCmt, eRfo, eHit, eStall, found, pushIt, rbNew;
    logic [DW-1:0] eData;
    settleEnv();
    eReady = (q.size() < DEPTH) && !fp;
    eCmt   = (q.size() != 0) && headOwned;
    eRfo   = (q.size() != 0) && !headOwned && !rb;
    eHit = 0; eStall = 0; found = 0; eData = '0;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (!found && (q[i].a[AW-1:2] == ldAddr[AW-1:2]) && ((q[i].m & ldMask) != 0)) begin
        found = 1;
        eData = q[i].d;
        if ((q[i].m & ldMask) == ldMask) eHit = 1; else eStall = 1;
      end
    end
    eHit   = ldValid && !fp && eHit;
    eStall = ldValid && (fp || eStall);
    chk("R2 stReady", stReady, eReady);
    chk("R9 memStall", memStall, fp);
    chk("R4 cmtValid", cmtValid, eCmt);
    if (eCmt) chk("R3 commit order", {cmtAddr, cmtData}, {q[0].a, q[0].d});
    if (eCmt) chk("R3 commit mask", cmtMask, q[0].m);
    chk("R5 rfoReq", rfoReq, eRfo);
    if (q.size() != 0) chk("R5 headLine", headLine, mLine);
    chk("R7 ldFwdHit", ldFwdHit, eHit);
    chk("R8 ldStall", ldStall, eStall);
    if (eHit) chk("R7 ldFwdData", ldFwdData, eData);
    @(posedge clk);
    pushIt = stValid && eReady;
    if (rfoAck) owned[mLine] = 1;
    if (eRfo) rbNew = 1;
    else if (rb && (rfoAck || (ownLost && ownLostLine == mLine))) rbNew = 0;
    else rbNew = rb;
    rb = rbNew;
    ackCnt = rb ? ackCnt + 1 : 0;
    if (eCmt) void'(q.pop_front());
    if (pushIt) q.push_back('{a: stAddr, d: stData, m: stMask});
    fp = fenceReq || (fp && q.size() != 0);
    @(negedge clk);
    stValid = 0; ldValid = 0; fenceReq = 0; ownLost = 0;
  endtask

  task automatic doStore(logic [AW-1:0] a, logic [DW-1:0] d, logic [MW-1:0] m);
    stValid = 1; stAddr = a; stData = d; stMask = m;
    step();
  endtask

  task automatic doLoad(logic [AW-1:0] a, logic [MW-1:0] m);
    ldValid = 1; ldAddr = a; ldMask = m;
    step();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    settleEnv();
    // R1: reset state
    chk("R1 stReady", stReady, 1);
    chk("R1 idle outputs", {cmtValid, rfoReq, memStall, ldFwdHit, ldStall}, 0);
    step();

    // R4: store to a pre-owned line commits in the following cycle
    owned[26'h4] = 1;
    doStore(32'h0000_0100, 32'hAAAA_0001, 4'hF);
    settleEnv();
    chk("R4 next-cycle commit", cmtValid, 1);
    step();

    // Fill with stores to unowned lines while ownership is withheld
    ackEn = 0;
    doStore(32'h0000_1000, 32'h1111_1111, 4'hF);
    doStore(32'h0000_2000, 32'h2222_2222, 4'hF);
    doStore(32'h0000_1000, 32'h3333_3333, 4'h3);
    doStore(32'h0000_3008, 32'h4444_4444, 4'hC);
    doStore(32'h0000_4000, 32'h5555_5555, 4'hF);
    doStore(32'h0000_5000, 32'h6666_6666, 4'hF);
    doStore(32'h0000_6000, 32'h7777_7777, 4'hF);
    doStore(32'h0000_7000, 32'h8888_8888, 4'hF);
    settleEnv();
    chk("R2 full blocks accept", stReady, 0);
    doStore(32'h0000_7700, 32'hDEAD_BEEF, 4'hF);

    // Forwarding patterns
    doLoad(32'h0000_1000, 4'h3);  // R7 youngest covering entry
    doLoad(32'h0000_1000, 4'hF);  // R8 partial cover
    doLoad(32'h0000_1000, 4'hC);  // R7 older entry past a disjoint younger one
    ldValid = 1; ldAddr = 32'h0000_3008; ldMask = 4'h1;
    settleEnv();
    chk("R10 disjoint bytes no hit/stall", {ldFwdHit, ldStall}, 0);
    step();
    ldValid = 1; ldAddr = 32'h0000_9000; ldMask = 4'hF;
    settleEnv();
    chk("R10 unmatched address", {ldFwdHit, ldStall}, 0);
    step();

    // R6: loss of an unrelated line, then of the requested line
    ownLost = 1; ownLostLine = 26'h41;
    step();
    settleEnv();
    chk("R6 other line ignored", rfoReq, 0);
    ownLost = 1; ownLostLine = 26'h40;
    step();
    settleEnv();
    chk("R6 reissue after loss", rfoReq, 1);
    step();

    // Grant ownership and drain in order
    ackEn = 1;
    for (int k = 0; k < 300 && q.size() != 0; k++) step();
    chk("R3 drained", q.size(), 0);

    // R9: fence with pending stores
    ackEn = 0;
    doStore(32'h0000_8000, 32'h9999_0000, 4'hF);
    doStore(32'h0000_8040, 32'h9999_0001, 4'hF);
    fenceReq = 1;
    step();
    settleEnv();
    chk("R9 fence stall", {memStall, stReady}, 2'b10);
    doStore(32'h0000_8080, 32'h9999_0002, 4'hF);
    doLoad(32'h0000_8000, 4'hF);
    ackEn = 1;
    for (int k = 0; k < 300 && (q.size() != 0 || fp); k++) step();
    settleEnv();
    chk("R9 fence released", {memStall, stReady}, 2'b01);

    // R9: fence on an empty buffer stalls one cycle
    fenceReq = 1;
    step();
    settleEnv();
    chk("R9 empty fence one cycle", memStall, 1);
    step();
    settleEnv();
    chk("R9 empty fence cleared", memStall, 0);
    step();

    summary();
    $finish;
  end
endmodule